// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block produces the instruction fetch address for a small pipelined 8-bit controller. The address has two parts. The upper part is a bank field, registered from an input each cycle. The lower part is a 13-bit program counter. Every clock of the block is one instruction cycle, and in each cycle the counter takes exactly one next value. The choices are:

- a sequential step
- a skip of one instruction
- a short jump made by writing the counter's low byte
- an absolute jump or call
- a return from an internal subroutine stack
- a jump to one of two fixed timer vectors

The decoder outside the block raises one request line per kind of transfer. The block chooses among the requests by fixed priority and registers the new address. It also registers a flush flag, which tells the fetch stage to replace the already prefetched instruction with a dummy cycle. Calls and accepted interrupts push the next sequential address onto an eight-entry ring stack, and returns pop it. Pushing onto a full stack or popping an empty one gives a one-cycle flag.

Top module: `fetch_pc_seq`

## Requirements
- R1: While rst_n is low, fetch_addr_o, pc_low_o, flush_o, stk_ovf_o and stk_unf_o are all zero, bank bits included, and the stack is emptied.
- R2: With no request active, the 13-bit counter advances by one and wraps from 8191 to 0. The two upper bits of fetch_addr_o (bits 14..13) take the value bank_i had at the previous edge, and pc_low_o equals fetch_addr_o[7:0].
- R3: skip_i advances the counter by two.
- R4: low_wr_i replaces counter bits 7..0 with low_data_i and keeps bits 12..8.
- R5: jump_i loads all 13 counter bits from target_i.
- R6: call_i loads target_i and pushes the counter value plus one.
- R7: ret_i loads the most recently pushed value and removes it from the stack.
- R8: tmr0_irq_i loads 0x008 and tmr1_irq_i loads 0x00C. Either one pushes the counter plus one, and the bank bits are not affected.
- R9: Requests are taken in this order: tmr0_irq_i, tmr1_irq_i, ret_i, call_i, jump_i, low_wr_i, skip_i, then the sequential step. A request that loses has no effect on the address or the stack.
- R10: The stack holds 8 entries. A push onto a full stack discards the oldest entry and drives stk_ovf_o high for exactly the next cycle.
- R11: A return with an empty stack loads 0 into the counter and drives stk_unf_o high for exactly the next cycle.
- R12: flush_o is high for exactly the cycle after any taken request other than the sequential step, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_i | input | 2 | Bank field supplied by the bank register |
| skip_i | input | 1 | Skip condition met |
| low_wr_i | input | 1 | Write to the counter low byte |
| low_data_i | input | 8 | Data for the low-byte write |
| jump_i | input | 1 | Absolute jump request |
| call_i | input | 1 | Subroutine call request |
| target_i | input | 13 | Immediate target for jump or call |
| ret_i | input | 1 | Return from subroutine |
| tmr0_irq_i | input | 1 | Timer 0 overflow vector request |
| tmr1_irq_i | input | 1 | Timer 1 overflow vector request |
| fetch_addr_o | output | 15 | Bank field above the 13-bit counter |
| pc_low_o | output | 8 | Readable low byte of the counter |
| flush_o | output | 1 | Discard the prefetched instruction |
| stk_ovf_o | output | 1 | Push onto a full stack (one cycle) |
| stk_unf_o | output | 1 | Pop from an empty stack (one cycle) |

## Verification
Every result of this block is due exactly one edge after the request that causes it. This holds for the new address, the bank bits, the flush flag and both stack flags. The bench drives requests on the falling edge and lets one rising edge pass. On the next falling edge it compares all outputs with a behavioural model, and only then drives the following request. The model uses integer arithmetic and a queue-based stack, and is advanced once per cycle. Same-cycle conflicts are driven on purpose, and so are stack wrap and stack exhaustion, so that the one-cycle flag pulses are checked at the edge they are due.

// File: rtl/fetch_pc_pkg.sv
package fetch_pc_pkg;

  typedef enum logic [2:0] {
    XF_SEQ  = 3'd0,
    XF_SKIP = 3'd1,
    XF_LOW  = 3'd2,
    XF_JUMP = 3'd3,
    XF_CALL = 3'd4,
    XF_RET  = 3'd5,
    XF_VEC0 = 3'd6,
    XF_VEC1 = 3'd7
  } xfer_e;

  function automatic logic is_redirect(xfer_e k);
    return k != XF_SEQ;
  endfunction

  function automatic logic is_push(xfer_e k);
    return (k == XF_CALL) || (k == XF_VEC0) || (k == XF_VEC1);
  endfunction

endpackage

// File: rtl/fetch_pc_arb.sv
module fetch_pc_arb
  import fetch_pc_pkg::*;
(
  input  logic  vec0_req_i,
  input  logic  vec1_req_i,
  input  logic  ret_req_i,
  input  logic  call_req_i,
  input  logic  jump_req_i,
  input  logic  low_req_i,
  input  logic  skip_req_i,
  output xfer_e kind_o
);

  // fixed priority: timers first, then the instruction's own transfer
  always_comb begin
    if (vec0_req_i)      kind_o = XF_VEC0;
    else if (vec1_req_i) kind_o = XF_VEC1;
    else if (ret_req_i)  kind_o = XF_RET;
    else if (call_req_i) kind_o = XF_CALL;
    else if (jump_req_i) kind_o = XF_JUMP;
    else if (low_req_i)  kind_o = XF_LOW;
    else if (skip_req_i) kind_o = XF_SKIP;
    else                 kind_o = XF_SEQ;
  end

endmodule

// File: rtl/fetch_pc_stack.sv
module fetch_pc_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_val_i,
  output logic [W-1:0] top_o,
  output logic         ovf_o,
  output logic         unf_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] ring_inc(logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ring_dec(logic [PW-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  logic is_empty, is_full;
  assign is_empty = (fill == '0);
  assign is_full  = (fill == FULL);

  assign top_o = is_empty ? '0 : mem[ring_dec(wr_ptr)];

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= push_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
      ovf_o  <= 1'b0;
      unf_o  <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      if (push_i) begin
        // ring overwrite keeps the newest DEPTH entries
        wr_ptr <= ring_inc(wr_ptr);
        if (!is_full) fill <= fill + 1'b1;
        ovf_o <= is_full;
      end else if (pop_i) begin
        if (!is_empty) begin
          wr_ptr <= ring_dec(wr_ptr);
          fill   <= fill - 1'b1;
        end
        unf_o <= is_empty;
      end
    end
  end

endmodule

// File: rtl/fetch_pc_seq.sv
module fetch_pc_seq
  import fetch_pc_pkg::*;
#(
  parameter int PC_W        = 13,
  parameter int BANK_W      = 2,
  parameter int LOW_W       = 8,
  parameter int STACK_DEPTH = 8,
  parameter logic [PC_W-1:0] VEC_T0 = 13'h008,
  parameter logic [PC_W-1:0] VEC_T1 = 13'h00C,
  localparam int ADDR_W = BANK_W + PC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              skip_i,
  input  logic              low_wr_i,
  input  logic [LOW_W-1:0]  low_data_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic [PC_W-1:0]   target_i,
  input  logic              ret_i,
  input  logic              tmr0_irq_i,
  input  logic              tmr1_irq_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [LOW_W-1:0]  pc_low_o,
  output logic              flush_o,
  output logic              stk_ovf_o,
  output logic              stk_unf_o
);

  function automatic logic [PC_W-1:0] pc_add(logic [PC_W-1:0] pc, int unsigned n);
    return pc + PC_W'(n);
  endfunction

  function automatic logic [PC_W-1:0] splice_low(logic [PC_W-1:0] pc, logic [LOW_W-1:0] b);
    logic [PC_W-1:0] r;
    r = pc;
    r[LOW_W-1:0] = b;
    return r;
  endfunction

  logic [PC_W-1:0]   pc_q, pc_d;
  logic [BANK_W-1:0] bank_q;
  logic              flush_q;
  logic [PC_W-1:0]   stk_top;
  logic [PC_W-1:0]   link_val;
  xfer_e             kind;

  // named events for the checker
  logic ev_seq, ev_skip, ev_low, ev_jump, ev_call, ev_ret, ev_vec0, ev_vec1;
  logic ev_push, ev_pop;

  fetch_pc_arb u_arb (
    .vec0_req_i (tmr0_irq_i),
    .vec1_req_i (tmr1_irq_i),
    .ret_req_i  (ret_i),
    .call_req_i (call_i),
    .jump_req_i (jump_i),
    .low_req_i  (low_wr_i),
    .skip_req_i (skip_i),
    .kind_o     (kind)
  );

  assign ev_seq  = (kind == XF_SEQ);
  assign ev_skip = (kind == XF_SKIP);
  assign ev_low  = (kind == XF_LOW);
  assign ev_jump = (kind == XF_JUMP);
  assign ev_call = (kind == XF_CALL);
  assign ev_ret  = (kind == XF_RET);
  assign ev_vec0 = (kind == XF_VEC0);
  assign ev_vec1 = (kind == XF_VEC1);
  assign ev_push = is_push(kind);
  assign ev_pop  = ev_ret;

  assign link_val = pc_add(pc_q, 1);

  fetch_pc_stack #(
    .DEPTH (STACK_DEPTH),
    .W     (PC_W)
  ) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (ev_push),
    .pop_i      (ev_pop),
    .push_val_i (link_val),
    .top_o      (stk_top),
    .ovf_o      (stk_ovf_o),
    .unf_o      (stk_unf_o)
  );

  always_comb begin
    unique case (kind)
      XF_VEC0: pc_d = VEC_T0;
      XF_VEC1: pc_d = VEC_T1;
      XF_RET:  pc_d = stk_top;
      XF_CALL: pc_d = target_i;
      XF_JUMP: pc_d = target_i;
      XF_LOW:  pc_d = splice_low(pc_q, low_data_i);
      XF_SKIP: pc_d = pc_add(pc_q, 2);
      default: pc_d = pc_add(pc_q, 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      bank_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      bank_q  <= bank_i;
      flush_q <= is_redirect(kind);
    end
  end

  assign fetch_addr_o = {bank_q, pc_q};
  assign pc_low_o     = pc_q[LOW_W-1:0];
  assign flush_o      = flush_q;

endmodule

// File: rtl/fetch_pc_checker.sv
module fetch_pc_checker #(
  parameter int PC_W  = 13,
  parameter int LOW_W = 8,
  parameter logic [PC_W-1:0] VEC_T0 = 13'h008,
  parameter logic [PC_W-1:0] VEC_T1 = 13'h00C
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PC_W-1:0]  pc,
  input logic [LOW_W-1:0] low_data_i,
  input logic [PC_W-1:0]  target_i,
  input logic             tmr0_irq_i,
  input logic             tmr1_irq_i,
  input logic             flush_o,
  input logic             stk_ovf_o,
  input logic             stk_unf_o,
  input logic             ev_seq,
  input logic             ev_skip,
  input logic             ev_low,
  input logic             ev_jump,
  input logic             ev_call,
  input logic             ev_ret,
  input logic             ev_push
);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq |=> (pc == PC_W'($past(pc) + 1'b1)) && !flush_o);

  assert_skip_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> (pc == PC_W'($past(pc) + 2'd2)) && flush_o);

  assert_low_splice_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_low |=> (pc[PC_W-1:LOW_W] == $past(pc[PC_W-1:LOW_W])) &&
               (pc[LOW_W-1:0] == $past(low_data_i)));

  assert_jump_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_jump || ev_call) |=> (pc == $past(target_i)) && flush_o);

  assert_vec0_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_irq_i |=> (pc == VEC_T0) && flush_o);

  assert_vec1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr1_irq_i && !tmr0_irq_i) |=> (pc == VEC_T1));

  assert_ovf_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf_o |-> $past(ev_push));

  assert_unf_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stk_unf_o |-> ($past(ev_ret) && pc == '0));

  assert_flag_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_ovf_o, stk_unf_o}));

endmodule

bind fetch_pc_seq fetch_pc_checker #(
  .PC_W   (PC_W),
  .LOW_W  (LOW_W),
  .VEC_T0 (VEC_T0),
  .VEC_T1 (VEC_T1)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc         (pc_q),
  .low_data_i (low_data_i),
  .target_i   (target_i),
  .tmr0_irq_i (tmr0_irq_i),
  .tmr1_irq_i (tmr1_irq_i),
  .flush_o    (flush_o),
  .stk_ovf_o  (stk_ovf_o),
  .stk_unf_o  (stk_unf_o),
  .ev_seq     (ev_seq),
  .ev_skip    (ev_skip),
  .ev_low     (ev_low),
  .ev_jump    (ev_jump),
  .ev_call    (ev_call),
  .ev_ret     (ev_ret),
  .ev_push    (ev_push)
);

// File: tb/fetch_pc_seq_tb_top.sv
module fetch_pc_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bank_i = '0;
  logic        skip_i = 0, low_wr_i = 0, jump_i = 0, call_i = 0, ret_i = 0;
  logic        tmr0_irq_i = 0, tmr1_irq_i = 0;
  logic [7:0]  low_data_i = '0;
  logic [12:0] target_i = '0;
  logic [14:0] fetch_addr_o;
  logic [7:0]  pc_low_o;
  logic        flush_o, stk_ovf_o, stk_unf_o;

  always #2.5 clk = ~clk;

  fetch_pc_seq dut_i (
    .clk (clk), .rst_n (rst_n), .bank_i (bank_i),
    .skip_i (skip_i), .low_wr_i (low_wr_i), .low_data_i (low_data_i),
    .jump_i (jump_i), .call_i (call_i), .target_i (target_i), .ret_i (ret_i),
    .tmr0_irq_i (tmr0_irq_i), .tmr1_irq_i (tmr1_irq_i),
    .fetch_addr_o (fetch_addr_o), .pc_low_o (pc_low_o), .flush_o (flush_o),
    .stk_ovf_o (stk_ovf_o), .stk_unf_o (stk_unf_o)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // behavioural reference model
  int    m_pc = 0, m_bank = 0;
  bit    m_flush = 0, m_ovf = 0, m_unf = 0;
  int    m_stk[$];
  string m_tag = "R1";

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk(m_tag, int'(fetch_addr_o), (m_bank << 13) | m_pc);
    chk("R2", int'(pc_low_o), m_pc & 8'hFF);
    chk("R12", int'(flush_o), int'(m_flush));
    chk("R10", int'(stk_ovf_o), int'(m_ovf));
    chk("R11", int'(stk_unf_o), int'(m_unf));
  endtask

  task automatic model_push(int v);
    m_stk.push_back(v);
    if (m_stk.size() > 8) begin
      void'(m_stk.pop_front());
      m_ovf = 1;
    end
  endtask

  // check previous result, drive one request set, advance the model
  task automatic step(bit t0, bit t1, bit r, bit c, bit j, bit lw, bit s,
                      int tg = 0, int d = 0, int bk = 0);
    check_outputs();
    tmr0_irq_i = t0; tmr1_irq_i = t1; ret_i = r; call_i = c; jump_i = j;
    low_wr_i = lw; skip_i = s;
    target_i = 13'(tg); low_data_i = 8'(d); bank_i = 2'(bk);
    m_ovf = 0; m_unf = 0; m_flush = 1;
    if (t0) begin
      model_push((m_pc + 1) % 8192); m_pc = 8; m_tag = "R9";
    end else if (t1) begin
      model_push((m_pc + 1) % 8192); m_pc = 12; m_tag = "R8";
    end else if (r) begin
      if (m_stk.size() == 0) begin m_pc = 0; m_unf = 1; m_tag = "R11"; end
      else begin m_pc = m_stk.pop_back(); m_tag = "R7"; end
    end else if (c) begin
      model_push((m_pc + 1) % 8192); m_pc = tg; m_tag = "R6";
    end else if (j) begin
      m_pc = tg; m_tag = "R5";
    end else if (lw) begin
      m_pc = (m_pc & 32'h1F00) | (d & 8'hFF); m_tag = "R4";
    end else if (s) begin
      m_pc = (m_pc + 2) % 8192; m_tag = "R3";
    end else begin
      m_pc = (m_pc + 1) % 8192; m_flush = 0; m_tag = "R2";
    end
    m_bank = bk;
    @(negedge clk);
  endtask

  task automatic do_reset(int cycles);
    rst_n = 1'b0;
    tmr0_irq_i = 0; tmr1_irq_i = 0; ret_i = 0; call_i = 0; jump_i = 0;
    low_wr_i = 0; skip_i = 0;
    m_pc = 0; m_bank = 0; m_flush = 0; m_ovf = 0; m_unf = 0; m_stk.delete();
    m_tag = "R1";
    repeat (cycles) @(negedge clk);
    check_outputs();  // R1 reset state
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(3);
    // R2: sequential steps with bank changes
    step(0,0,0,0,0,0,0, 0,0, 1);
    step(0,0,0,0,0,0,0, 0,0, 2);
    step(0,0,0,0,0,0,0, 0,0, 3);
    // R5 jump to top, then R2 wrap to 0
    step(0,0,0,0,1,0,0, 8191,0, 3);
    step(0,0,0,0,0,0,0, 0,0, 3);
    step(0,0,0,0,0,0,0, 0,0, 0);
    // R3 skip, R4 low-byte write keeping upper bits
    step(0,0,0,0,1,0,0, 13'h1234,0, 1);
    step(0,0,0,0,0,0,1, 0,0, 1);
    step(0,0,0,0,0,1,0, 0,8'hA5, 1);
    step(0,0,0,0,0,0,0, 0,0, 1);
    // R6 call and R7 return
    step(0,0,0,1,0,0,0, 13'h0400,0, 2);
    step(0,0,0,0,0,0,0, 0,0, 2);
    step(0,0,1,0,0,0,0, 0,0, 2);
    // R8 timer vectors, bank kept
    step(0,0,0,0,0,0,0, 0,0, 3);
    step(0,1,0,0,0,0,0, 0,0, 3);
    step(0,0,1,0,0,0,0, 0,0, 3);
    step(1,0,0,0,0,0,0, 0,0, 2);
    step(0,0,1,0,0,0,0, 0,0, 2);
    // R9 conflicts: both timers, timer vs return/call, instruction ordering
    step(1,1,1,1,1,1,1, 13'h0777,8'h11, 1);
    step(0,1,1,1,0,0,0, 13'h0666,0, 1);
    step(0,0,1,1,1,0,0, 13'h0555,0, 1);
    step(0,0,1,0,0,0,0, 0,0, 1);
    step(0,0,0,1,1,1,1, 13'h0321,8'h22, 1);
    step(0,0,0,0,1,1,1, 13'h0abc,8'h33, 1);
    step(0,0,0,0,0,1,1, 0,8'h44, 1);
    // drain the stack, then R11 underflow
    for (int k = 0; k < 4; k++) step(0,0,1,0,0,0,0, 0,0, 0);
    step(0,0,1,0,0,0,0, 0,0, 0);
    step(0,0,0,0,0,0,0, 0,0, 0);
    // R10: nine calls overflow the 8-entry stack, nine returns
    for (int k = 0; k < 9; k++) step(0,0,0,1,0,0,0, 100 * (k + 1),0, 0);
    for (int k = 0; k < 9; k++) step(0,0,1,0,0,0,0, 0,0, 0);
    // R1 mid-run reset
    check_outputs();
    do_reset(2);
    step(0,0,0,0,0,0,0, 0,0, 2);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      int unsigned w = $urandom_range(99);
      step(w < 3, (w >= 3 && w < 6), (w >= 6 && w < 16), (w >= 16 && w < 26),
           (w >= 26 && w < 32), (w >= 32 && w < 38), (w >= 38 && w < 46),
           int'($urandom_range(8191)), int'($urandom_range(255)),
           int'($urandom_range(3)));
    end
    check_outputs();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule